// File: doc/BRIEF.md
# Ringing-to-Idle Transition Sequencer

This block drives a solid-state line-card access switch through the handover from power ringing to the idle/talk state. It owns four host-side control pins: the two state-select inputs of the switch, its input latch enable, and an open-drain pull on the switch's shutdown override pin. A one-cycle `ring_set_i` pulse puts the line into ringing. A `start_i` pulse then runs the handover in one of three modes. Make-before-break goes straight to idle. Logic break-before-make parks the switch in all-off long enough for the ring-access element to open at its next current zero crossing, then selects idle. Override break-before-make pulls the override pin low, swaps the select inputs underneath that forced all-off, and releases the pin once the hold has elapsed.

The hold is counted from a 1 ms `tick_i` strobe, so the window is `HOLD_TICKS` ticks (25 by default). That covers half a ringing period with margin. The override pin is never driven high, because driving it high would defeat the switch's thermal shutdown. The block only pulls it low or lets it float.

Select code on {`sw_ring_o`,`sw_acc_o`}: 2'b10 ringing, 2'b00 idle/talk, 2'b11 all-off. Mode code on `mode_i`: 2'b00 make-before-break, 2'b01 logic break-before-make, 2'b10 override break-before-make, 2'b11 treated as 2'b01.

Top module: `ring_idle_seq`

## Requirements
- R1: After reset the select code is 2'b00, `latch_o` is 1, and `ovr_pull_o`, `busy_o` and `done_o` are all 0.
- R2: In the resting idle state, a `ring_set_i` pulse sets the select code to 2'b10 and `latch_o` to 0 on the next clock edge. `ring_set_i` has no effect in any other state.
- R3: With mode 2'b00, a `start_i` accepted while ringing changes the select code from 2'b10 to 2'b00 at the accepting edge. No intermediate code appears and `busy_o` never rises.
- R4: With mode 2'b01 or 2'b11, the accepting edge sets the select code to 2'b11 and raises `busy_o`. The code stays 2'b11 until the edge that samples the `HOLD_TICKS`-th tick after the accepting edge, and at that edge it becomes 2'b00.
- R5: With mode 2'b10, the accepting edge asserts `ovr_pull_o` while the select code is still 2'b10. The next edge changes the code to 2'b00 with the pull still asserted.
- R6: In override mode, `ovr_pull_o` is released at the edge that samples the `HOLD_TICKS`-th tick after the accepting edge, and `busy_o` falls at that same edge.
- R7: `start_i` is ignored while `busy_o` is high and while resting idle. `mode_i` is sampled only at the accepting edge.
- R8: `done_o` pulses high for exactly one cycle, in the cycle in which code 2'b00 is first applied at the end of a sequence.
- R9: `latch_o` is 0 (transparent) whenever the block is ringing, busy or signalling done, and is 1 only when resting idle.
- R10: `ovr_pull_o` is asserted only during an override sequence, and the select code is never 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_set_i | input | 1 | Enter ringing (pulse, honoured only when resting idle) |
| start_i | input | 1 | Begin ringing-to-idle handover (pulse) |
| mode_i | input | 2 | Handover mode, sampled at acceptance |
| tick_i | input | 1 | 1 ms timebase strobe |
| sw_ring_o | output | 1 | Switch state-select bit 1 |
| sw_acc_o | output | 1 | Switch state-select bit 0 |
| latch_o | output | 1 | Switch input latch enable (1 = hold) |
| ovr_pull_o | output | 1 | Open-drain pull-down enable on the override pin (1 = pull low, 0 = float) |
| busy_o | output | 1 | Handover in progress |
| done_o | output | 1 | One-cycle pulse when idle has been applied |

## Verification
The bench runs each mode with sparse ticks and with a tick on every cycle. Off-by-one errors in the hold count show up as a release one tick early or late. Starts, ring requests and mode changes are fired mid-hold; a design that re-arms or re-samples the mode would restart the window or swap the override pin state. In override mode the ordering is checked: the pull must lead the select change by one edge and end with the release. A design that swapped first would let the switch see a ringing-to-idle change with no all-off in between. A reset applied mid-sequence must drop the pull at once, or the switch would stay forced off.

// File: rtl/ring_idle_seq_pkg.sv
package ring_idle_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RING     = 3'd1,
        ST_BBM_HOLD = 3'd2,
        ST_OVR_PULL = 3'd3,
        ST_OVR_HOLD = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_MBB  = 2'b00,
        MD_LBBM = 2'b01,
        MD_OBBM = 2'b10,
        MD_ALT  = 2'b11
    } seq_mode_e;

    // select code {ring bit, access bit}
    localparam logic [1:0] SEL_IDLE = 2'b00;
    localparam logic [1:0] SEL_RING = 2'b10;
    localparam logic [1:0] SEL_OFF  = 2'b11;

    typedef struct packed {
        seq_state_e st;
        logic [1:0] sel;
        logic       pull;
        logic       latch;
        logic       done;
    } seq_regs_t;

endpackage

// File: rtl/seq_hold_timer.sv
module seq_hold_timer #(
    parameter int HOLD_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic expire_o
);
    localparam int CW = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == LAST);
endmodule

// File: rtl/seq_core.sv
module seq_core
    import ring_idle_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ring_set_i,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       tick_i,
    input  logic       expire_i,
    output logic       clr_o,
    output logic       inc_o,
    output seq_regs_t  regs_o
);
    seq_regs_t r_d, r_q;
    seq_state_e nst;
    logic       fin;

    always_comb begin
        nst   = r_q.st;
        fin   = 1'b0;
        clr_o = 1'b0;
        inc_o = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (ring_set_i) nst = ST_RING;
            ST_RING: if (start_i) begin
                case (seq_mode_e'(mode_i))
                    MD_MBB: begin
                        nst = ST_IDLE;
                        fin = 1'b1;
                    end
                    MD_OBBM: begin
                        nst   = ST_OVR_PULL;
                        clr_o = 1'b1;
                    end
                    default: begin
                        nst   = ST_BBM_HOLD;
                        clr_o = 1'b1;
                    end
                endcase
            end
            ST_OVR_PULL: begin
                nst   = ST_OVR_HOLD;
                inc_o = tick_i;
            end
            ST_BBM_HOLD, ST_OVR_HOLD: if (tick_i) begin
                if (expire_i) begin
                    nst = ST_IDLE;
                    fin = 1'b1;
                end else begin
                    inc_o = 1'b1;
                end
            end
            default: nst = ST_IDLE;
        endcase

        r_d.st    = nst;
        r_d.done  = fin;
        r_d.pull  = (nst == ST_OVR_PULL) || (nst == ST_OVR_HOLD);
        r_d.latch = (nst == ST_IDLE) && !fin;
        unique case (nst)
            ST_RING, ST_OVR_PULL: r_d.sel = SEL_RING;
            ST_BBM_HOLD:          r_d.sel = SEL_OFF;
            default:              r_d.sel = SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.sel   <= SEL_IDLE;
            r_q.pull  <= 1'b0;
            r_q.latch <= 1'b1;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs_o = r_q;
endmodule

// File: rtl/ring_idle_seq.sv
module ring_idle_seq
    import ring_idle_seq_pkg::*;
#(
    parameter int HOLD_TICKS = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ring_set_i,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       tick_i,
    output logic       sw_ring_o,
    output logic       sw_acc_o,
    output logic       latch_o,
    output logic       ovr_pull_o,
    output logic       busy_o,
    output logic       done_o
);
    logic      clr, inc, expire;
    seq_regs_t regs;

    seq_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .inc_i    (inc),
        .expire_o (expire)
    );

    seq_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_set_i (ring_set_i),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .tick_i     (tick_i),
        .expire_i   (expire),
        .clr_o      (clr),
        .inc_o      (inc),
        .regs_o     (regs)
    );

    assign sw_ring_o  = regs.sel[1];
    assign sw_acc_o   = regs.sel[0];
    assign latch_o    = regs.latch;
    assign ovr_pull_o = regs.pull;
    assign done_o     = regs.done;
    assign busy_o     = (regs.st == ST_BBM_HOLD) || (regs.st == ST_OVR_PULL)
                     || (regs.st == ST_OVR_HOLD);
endmodule

// File: rtl/ring_idle_seq_chk.sv
module ring_idle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_ring_o,
    input logic sw_acc_o,
    input logic latch_o,
    input logic ovr_pull_o,
    input logic busy_o,
    input logic done_o
);
    logic [1:0] sel;
    assign sel = {sw_ring_o, sw_acc_o};

    AST_LBBM_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ovr_pull_o) |-> sel == 2'b11); // R4
    AST_PULL_BEFORE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_pull_o) |-> sel == 2'b10); // R5
    AST_SWAP_UNDER_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_pull_o) |=> (ovr_pull_o && sel == 2'b00)); // R5
    AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_pull_o) |-> (done_o && !busy_o && sel == 2'b00)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sel == 2'b00 && !busy_o && !ovr_pull_o)); // R8
    AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || done_o || sel != 2'b00) |-> !latch_o); // R9
    AST_NO_TEST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'b01); // R10
    AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pull_o |-> busy_o); // R10
    AST_MBB_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) == 2'b10 && sel == 2'b00 && !$past(ovr_pull_o)) |-> done_o); // R3
endmodule

bind ring_idle_seq ring_idle_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_ring_o  (sw_ring_o),
    .sw_acc_o   (sw_acc_o),
    .latch_o    (latch_o),
    .ovr_pull_o (ovr_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/test_ring_idle_seq.sv
`timescale 1ns/1ps
module test_ring_idle_seq;
    localparam int H = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_set = 1'b0, start = 1'b0, tick = 1'b0;
    logic [1:0] mode = 2'b00;
    logic sw_ring, sw_acc, latch, pull, busy, done;

    int vectors = 0, fails = 0, cycles = 0;
    int tick_per = 0, tick_ph = 0;

    // reference model
    int m_st = 0, m_cnt = 0;
    logic m_done = 1'b0;
    string ctx = "R1";

    always #10 clk = ~clk;

    ring_idle_seq #(.HOLD_TICKS(H)) i_ring_idle_seq (
        .clk(clk), .rst_n(rst_n), .ring_set_i(ring_set), .start_i(start),
        .mode_i(mode), .tick_i(tick), .sw_ring_o(sw_ring), .sw_acc_o(sw_acc),
        .latch_o(latch), .ovr_pull_o(pull), .busy_o(busy), .done_o(done)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_done = 1'b0; ctx = "R1";
        end else begin
            m_done = 1'b0;
            case (m_st)
                0: if (ring_set) begin m_st = 1; ctx = "R2"; end
                1: if (start) begin
                    if (mode == 2'b00) begin m_st = 0; m_done = 1'b1; ctx = "R3"; end
                    else if (mode == 2'b10) begin m_st = 3; m_cnt = 0; ctx = "R5"; end
                    else begin m_st = 2; m_cnt = 0; ctx = "R4"; end
                end
                2, 4: if (tick) begin
                    m_cnt++;
                    if (m_cnt == H) begin
                        m_st = 0; m_done = 1'b1;
                        if (ctx == "R5") ctx = "R6";
                    end
                end
                3: begin if (tick) m_cnt++; m_st = 4; end
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_sel();
        case (m_st)
            1, 3: return 2;
            2:    return 3;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        cycles++;
        chk({sw_ring, sw_acc} == 2'(exp_sel()), ctx, {sw_ring, sw_acc}, exp_sel());
        chk(pull == (m_st == 3 || m_st == 4), "R10", pull, (m_st == 3 || m_st == 4));
        chk(busy == (m_st >= 2), "R7", busy, (m_st >= 2));
        chk(done == m_done, "R8", done, m_done);
        chk(latch == (m_st == 0 && !m_done), "R9", latch, (m_st == 0 && !m_done));
        chk({sw_ring, sw_acc} != 2'b01, "R10", {sw_ring, sw_acc}, 2);
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        #2;
        if (tick_per == 0) tick = 1'b0;
        else begin
            tick = (tick_ph == 0);
            tick_ph = (tick_ph + 1) % tick_per;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_ring();
        ring_set = 1'b1; step(1); ring_set = 1'b0;
    endtask

    task automatic pulse_start(input logic [1:0] m);
        mode = m; start = 1'b1; step(1); start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 2000) begin step(1); n++; end
        chk(done && {sw_ring, sw_acc} == 2'b00, tag, done, 1);
        step(1);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        chk({sw_ring, sw_acc, latch, pull, busy, done} == 6'b001000, "R1",
            {sw_ring, sw_acc, latch, pull, busy, done}, 6'b001000);

        // start while resting idle is ignored
        pulse_start(2'b01);
        chk(!busy && latch, "R7", busy, 0);
        pulse_ring();
        chk({sw_ring, sw_acc} == 2'b10 && !latch, "R2", {sw_ring, sw_acc}, 2);
        pulse_ring(); // no effect while ringing
        chk({sw_ring, sw_acc} == 2'b10, "R2", {sw_ring, sw_acc}, 2);

        // make-before-break
        pulse_start(2'b00);
        chk(done && !busy && {sw_ring, sw_acc} == 2'b00, "R3", done, 1);
        step(1);
        chk(!done, "R8", done, 0);

        // logic break-before-make, sparse ticks, disturbances mid-hold
        tick_per = 3;
        pulse_ring();
        pulse_start(2'b01);
        chk({sw_ring, sw_acc} == 2'b11 && busy, "R4", {sw_ring, sw_acc}, 3);
        step(10);
        pulse_start(2'b10);
        pulse_ring();
        chk(!pull && {sw_ring, sw_acc} == 2'b11, "R7", pull, 0);
        wait_done("R4");

        // alternate code 11 behaves as logic break-before-make
        tick_per = 1;
        pulse_ring();
        pulse_start(2'b11);
        chk({sw_ring, sw_acc} == 2'b11, "R4", {sw_ring, sw_acc}, 3);
        wait_done("R4");

        // override mode, tick every cycle
        pulse_ring();
        pulse_start(2'b10);
        chk(pull && {sw_ring, sw_acc} == 2'b10, "R5", pull, 1);
        step(1);
        chk(pull && {sw_ring, sw_acc} == 2'b00, "R5", {sw_ring, sw_acc}, 0);
        pulse_start(2'b00);
        chk(busy && pull, "R7", busy, 1);
        wait_done("R6");
        chk(!pull, "R6", pull, 0);

        // override mode, sparse ticks
        tick_per = 5;
        pulse_ring();
        pulse_start(2'b10);
        wait_done("R6");

        // reset mid-sequence drops the pull
        pulse_ring();
        pulse_start(2'b10);
        step(4);
        rst_n = 1'b0;
        step(1);
        chk(!pull && !busy && latch, "R1", pull, 0);
        rst_n = 1'b1;
        step(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule